// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block produces an active-low processor reset from digitized fault indications: a supply-below-threshold flag, a manual-reset pin and a secondary-supply-good flag. Once every fault has cleared, the reset is held for a further stretch period so the processor starts on stable power. A watchdog watches a toggle line driven by processor software. If that line sits at one level for too long, the watchdog forces a reset pulse. While the line stays stuck, these pulses repeat.

All timing is counted in clock cycles and set by parameters. The manual-reset, secondary-supply and watchdog inputs pass through two-flop synchronizers. A watchdog level change counts as activity only after it has held for a minimum number of cycles, so short glitches cannot feed the watchdog.

The core is a three-state machine. HOLD means a fault is present. STRETCH means the stretch counter is running. RUN means reset is released. The transitions are:
- FAULT: any state goes to HOLD when a fault is present.
- CLEAR: HOLD goes to STRETCH once the faults are gone.
- DONE: STRETCH goes to RUN when the counter reaches its last value.
- BITE: RUN goes to STRETCH on a watchdog trip.

Top module: `sup_reset_gen`

## Requirements
- R1: While `vlow_i` is 1 (supply below threshold), `rst_n_o` is 0 from the clock edge that samples it.
- R2: `mr_n_i` at 0 (manual reset) drives `rst_n_o` to 0 three clock edges after the change, two of those edges being synchronizer delay.
- R3: `sec_ok_i` at 0 (secondary supply low) drives `rst_n_o` to 0 three clock edges after the change.
- R4: After the last fault clears, `rst_n_o` stays 0 for `RST_CYC` further cycles. A fault that returns during the stretch restarts the stretch from zero once it clears again.
- R5: While `por_n` is 0, `rst_n_o` is 0. After `por_n` rises, `rst_n_o` rises on the `RST_CYC`-th clock edge.
- R6: If `wdi_i` holds one level, `rst_n_o` falls `WD_CYC` cycles after it was released and stays 0 for exactly `RST_CYC` cycles.
- R7: With `wdi_i` still stuck, the reset pulse repeats with a period of `WD_CYC + RST_CYC` cycles.
- R8: A rising or a falling change on `wdi_i`, once qualified, restarts the watchdog count. The timeout edge is then `2 + MIN_PULSE + WD_CYC` edges after the change.
- R9: A `wdi_i` excursion shorter than `MIN_PULSE` cycles is ignored. One of exactly `MIN_PULSE` cycles is accepted.
- R10: The watchdog count is held at zero while reset is asserted, however long that lasts. Each release therefore gets a full `WD_CYC` period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vlow_i | input | 1 | Supply-below-threshold flag, 1 = low supply (synchronous) |
| mr_n_i | input | 1 | Manual-reset request, active low |
| sec_ok_i | input | 1 | Secondary-supply-good flag, 0 = fault |
| wdi_i | input | 1 | Watchdog toggle input from software |
| rst_n_o | output | 1 | Processor reset, active low |

## Verification
Each result has a fixed due edge, counted from the falling edge on which the bench drives the stimulus:
- The supply flag acts after one edge.
- Manual reset and the secondary flag act after three edges.
- A release is due `1+RST_CYC` edges after a clear of the supply flag and `3+RST_CYC` edges after a clear of a synchronized input.
- A watchdog bite is due `WD_CYC` edges after a release, or `2+MIN_PULSE+WD_CYC` edges after a qualified toggle.

Every timing check samples on the falling edge one cycle before the due edge and again right after it. An off-by-one in any counter or synchronizer therefore fails one of the two samples.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'b00,
        ST_STRETCH = 2'b01,
        ST_RUN     = 2'b10
    } sup_state_e;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic st1_q;
        logic st2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st1_q <= RST_VAL[b];
                st2_q <= RST_VAL[b];
            end else begin
                st1_q <= d_i[b];
                st2_q <= st1_q;
            end
        end

        assign q_o[b] = st2_q;
    end

endmodule

// File: rtl/sup_wdog_qual.sv
module sup_wdog_qual
    import sup_pkg::*;
#(
    parameter int MIN_PULSE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic act_o
);

    localparam int            GW     = cnt_width(MIN_PULSE);
    localparam logic [GW-1:0] G_LAST = GW'(MIN_PULSE - 1);

    logic          q_q;
    logic [GW-1:0] g_q;
    logic          differ;

    assign differ = (lvl_i != q_q);
    assign act_o  = differ && (g_q == G_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
            g_q <= '0;
        end else if (!differ) begin
            g_q <= '0;
        end else if (g_q == G_LAST) begin
            q_q <= lvl_i;
            g_q <= '0;
        end else begin
            g_q <= g_q + GW'(1);
        end
    end

    if (MIN_PULSE > 1) begin : g_chk
        // R9: an accepted change must have held its level across the previous cycle
        assert_qual_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
            act_o |-> ($past(lvl_i) == lvl_i));
    end

    assert_qual_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        g_q <= G_LAST);

endmodule

// File: rtl/sup_wdog_timer.sv
module sup_wdog_timer
    import sup_pkg::*;
#(
    parameter int WD_CYC = 80_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic act_i,
    output logic trip_o
);

    localparam int            WW     = cnt_width(WD_CYC);
    localparam logic [WW-1:0] W_LAST = WW'(WD_CYC - 1);

    logic [WW-1:0] w_q;

    assign trip_o = !hold_i && !act_i && (w_q == W_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (hold_i || act_i || (w_q == W_LAST)) begin
            w_q <= '0;
        end else begin
            w_q <= w_q + WW'(1);
        end
    end

    assert_wd_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (w_q == '0));

    assert_wd_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (w_q == '0));

    assert_wd_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |=> (w_q == '0));

    assert_wd_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        w_q <= W_LAST);

endmodule

// File: rtl/sup_stretch_fsm.sv
module sup_stretch_fsm
    import sup_pkg::*;
#(
    parameter int RST_CYC = 7_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic trip_i,
    output logic rst_n_o
);

    localparam int            CW     = cnt_width(RST_CYC);
    localparam logic [CW-1:0] C_LAST = CW'(RST_CYC - 1);

    sup_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!fault_i) state_d = ST_STRETCH;          // CLEAR
            end
            ST_STRETCH: begin
                if (fault_i)                state_d = ST_HOLD; // FAULT
                else if (cnt_q == C_LAST)   state_d = ST_RUN;  // DONE
            end
            ST_RUN: begin
                if (fault_i)     state_d = ST_HOLD;           // FAULT
                else if (trip_i) state_d = ST_STRETCH;        // BITE
            end
            default: state_d = ST_HOLD;
        endcase
        cnt_d = ((state_q == ST_STRETCH) && (state_d == ST_STRETCH)) ? cnt_q + CW'(1) : '0;
    end

    // state register; power-on starts a full stretch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STRETCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output decode
    always_comb begin
        rst_n_o = (state_q == ST_RUN);
    end

    assert_fault_asserts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !rst_n_o);

    assert_release_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> $past(!fault_i));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= C_LAST);

    assert_bite_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && trip_i && !fault_i) |=> (state_q == ST_STRETCH && cnt_q == '0));

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int RST_CYC   = 7_000_000,
    parameter int WD_CYC    = 80_000_000,
    parameter int MIN_PULSE = 5
) (
    input  logic clk,
    input  logic por_n,
    input  logic vlow_i,
    input  logic mr_n_i,
    input  logic sec_ok_i,
    input  logic wdi_i,
    output logic rst_n_o
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw, synced;
    logic mr_n_s, sec_ok_s, wdi_s;
    logic fault, act, trip, hold;

    assign raw = {wdi_i, sec_ok_i, mr_n_i};

    sup_sync2 #(
        .W       (NSYNC),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    assign mr_n_s   = synced[0];
    assign sec_ok_s = synced[1];
    assign wdi_s    = synced[2];

    assign fault = vlow_i | ~mr_n_s | ~sec_ok_s;
    assign hold  = ~rst_n_o;

    sup_wdog_qual #(
        .MIN_PULSE (MIN_PULSE)
    ) u_qual (
        .clk   (clk),
        .rst_n (por_n),
        .lvl_i (wdi_s),
        .act_o (act)
    );

    sup_wdog_timer #(
        .WD_CYC (WD_CYC)
    ) u_wdt (
        .clk    (clk),
        .rst_n  (por_n),
        .hold_i (hold),
        .act_i  (act),
        .trip_o (trip)
    );

    sup_stretch_fsm #(
        .RST_CYC (RST_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (por_n),
        .fault_i (fault),
        .trip_i  (trip),
        .rst_n_o (rst_n_o)
    );

    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!por_n)
        vlow_i |=> !rst_n_o);

    assert_manual_R2: assert property (@(posedge clk) disable iff (!por_n)
        !mr_n_s |=> !rst_n_o);

    assert_secondary_R3: assert property (@(posedge clk) disable iff (!por_n)
        !sec_ok_s |=> !rst_n_o);

endmodule

// File: tb/sup_reset_gen_tb_top.sv
module sup_reset_gen_tb_top;

    localparam int RST = 20;
    localparam int WD  = 40;
    localparam int MP  = 3;

    logic clk = 1'b0;
    logic por_n, vlow, mr_n, sec_ok, wdi;
    logic rst_n;

    int checks = 0;
    int errs   = 0;

    always #10 clk = ~clk;

    sup_reset_gen #(
        .RST_CYC   (RST),
        .WD_CYC    (WD),
        .MIN_PULSE (MP)
    ) dut_i (
        .clk      (clk),
        .por_n    (por_n),
        .vlow_i   (vlow),
        .mr_n_i   (mr_n),
        .sec_ok_i (sec_ok),
        .wdi_i    (wdi),
        .rst_n_o  (rst_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (rst_n !== exp) begin
            errs++;
            $display("FAIL %s: rst_n_o=%b expected %b at %0t", tag, rst_n, exp, $time);
        end
    endtask

    // force a supply-low pulse and stop on the cycle of release
    task automatic fresh_release();
        vlow = 1'b1; tick(1);
        vlow = 1'b0; tick(RST + 1);
        chk(1'b1, "R4 release after supply pulse");
    endtask

    task automatic t_por();
        tick(3);
        chk(1'b0, "R5 asserted during power-on reset");
        por_n = 1'b1;
        tick(RST - 1); chk(1'b0, "R5 still held before stretch end");
        tick(1);       chk(1'b1, "R5 release on stretch end");
    endtask

    task automatic t_vlow();
        fresh_release();
        vlow = 1'b1; tick(1); chk(1'b0, "R1 supply low asserts");
        tick(5);              chk(1'b0, "R1 held while supply low");
        vlow = 1'b0; tick(RST); chk(1'b0, "R4 stretch last cycle");
        tick(1);                chk(1'b1, "R4 stretch over");
    endtask

    task automatic t_mr();
        fresh_release();
        mr_n = 1'b0; tick(2); chk(1'b1, "R2 not yet through synchronizer");
        tick(1);               chk(1'b0, "R2 manual reset asserts");
        tick(4);
        mr_n = 1'b1; tick(2 + RST); chk(1'b0, "R2 stretch after manual");
        tick(1);                    chk(1'b1, "R2 release after manual");
    endtask

    task automatic t_sec();
        fresh_release();
        sec_ok = 1'b0; tick(2); chk(1'b1, "R3 not yet through synchronizer");
        tick(1);                 chk(1'b0, "R3 secondary low asserts");
        tick(4);
        sec_ok = 1'b1; tick(2 + RST); chk(1'b0, "R3 stretch after secondary");
        tick(1);                      chk(1'b1, "R3 release after secondary");
    endtask

    task automatic t_overlap();
        fresh_release();
        vlow = 1'b1; mr_n = 1'b0; tick(5);
        vlow = 1'b0; tick(5); chk(1'b0, "R4 other fault still active");
        mr_n = 1'b1; tick(2 + RST); chk(1'b0, "R4 stretch counts from last clear");
        tick(1);                    chk(1'b1, "R4 release after last clear");
    endtask

    task automatic t_restart();
        fresh_release();
        vlow = 1'b1; tick(1); vlow = 1'b0; tick(5);
        vlow = 1'b1; tick(1); vlow = 1'b0;
        tick(RST); chk(1'b0, "R4 stretch restarted");
        tick(1);   chk(1'b1, "R4 release after restart");
    endtask

    task automatic t_stuck();
        fresh_release();
        tick(WD - 1); chk(1'b1, "R6 before watchdog timeout");
        tick(1);      chk(1'b0, "R6 watchdog bite");
        tick(RST - 1); chk(1'b0, "R6 bite pulse length");
        tick(1);       chk(1'b1, "R6 bite pulse ends");
        tick(WD - 1);  chk(1'b1, "R7 second period high");
        tick(1);       chk(1'b0, "R7 repeated bite");
        tick(RST);     chk(1'b1, "R7 repeated bite ends");
    endtask

    task automatic t_kick(input logic lvl);
        fresh_release();
        tick(10);
        wdi = lvl;
        tick(1 + MP + WD); chk(1'b1, "R8 timer restarted by edge");
        tick(1);           chk(1'b0, "R8 bite after restarted period");
    endtask

    task automatic t_glitch();
        logic base;
        fresh_release();
        base = wdi;
        tick(5);
        wdi = ~base; tick(MP - 1); wdi = base;
        tick(WD - 5 - MP); chk(1'b1, "R9 short glitch ignored (high)");
        tick(1);           chk(1'b0, "R9 short glitch ignored (bite on time)");
        fresh_release();
        wdi = ~base; tick(MP); wdi = base;
        tick(1 + MP + WD); chk(1'b1, "R9 minimum pulse accepted");
        tick(1);           chk(1'b0, "R9 bite after accepted pulse");
    endtask

    task automatic t_hold();
        fresh_release();
        mr_n = 1'b0; tick(3 * WD); chk(1'b0, "R10 long manual reset");
        mr_n = 1'b1; tick(2 + RST); chk(1'b0, "R10 stretch");
        tick(1);      chk(1'b1, "R10 release");
        tick(WD - 1); chk(1'b1, "R10 full watchdog period after hold");
        tick(1);      chk(1'b0, "R10 bite on time");
    endtask

    initial begin
        por_n = 1'b0; vlow = 1'b0; mr_n = 1'b1; sec_ok = 1'b1; wdi = 1'b0;
        t_por();
        t_vlow();
        t_mr();
        t_sec();
        t_overlap();
        t_restart();
        t_stuck();
        t_kick(1'b1);
        t_kick(1'b0);
        t_glitch();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule